// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block produces the gated internal processor clock from two oscillator inputs: a fast main oscillator and a slow sub-oscillator. In normal running the internal clock toggles once per rising edge of the selected oscillator, so it runs at half that oscillator's rate. A small register set selects the source, turns the main oscillator off and sets the oscillator drive strength. The block also arms a stop-recovery countdown and enables a status pin.

A stop request freezes the internal clock high and switches off both oscillators. It stays frozen until an external interrupt arrives. The oscillators then restart, and a prescaled, cascaded pair of 8-bit down-counters gives them time to settle before the clock resumes. The counters start from fixed values or from programmed ones. A wait request also freezes the clock high but leaves the oscillators running. Reset or an interrupt from an allowed source ends the wait, and the clock resumes with no delay.

The oscillator inputs are taken as levels sampled on the block clock `clk`. One sampled 0-to-1 change is one oscillator rising edge.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset, `phi_o` is 1, both oscillator enables are 1, `osc_drive_strong_o` is 1 and `clkctl_o` is 0. While running, `phi_o` inverts on every sampled rising edge of the selected source, which is the main oscillator after reset.
- R2: Writing register 0 with bit 7 = 1 selects the sub-oscillator, and bit 7 = 0 selects the main oscillator. The selection changes only on a sample where both oscillator inputs are low.
- R3: While register 0 bit 6 is 1, `main_osc_en_o` is 0 and `sub_osc_en_o` stays 1.
- R4: `osc_drive_strong_o` follows register 0 bit 5. That bit resets to 1.
- R5: A `stop_req_i` pulse while running sets `phi_o` to 1 and both oscillator enables to 0 from the next clock. This state holds until `irq_ext_i`. `irq_req_i` and `wait_req_i` have no effect during stop.
- R6: After `irq_ext_i` ends a stop, the oscillator enables return to their register values. `phi_o` stays 1 through the next 16·(A+1)·(B+1) rising edges of the selected source, where A and B are the first-stage and second-stage start values. `phi_o` inverts on the edge after those.
- R7: The countdown starts from A = 255 and B = 7. When register 1 bit 7 is 1, it starts instead from A = register 2 and B = register 3. Registers are addressed by `reg_sel_i` (0 mode, 1 control, 2 first stage, 3 second stage).
- R8: A `wait_req_i` pulse while running holds `phi_o` at 1 and keeps the oscillator enables unchanged. `irq_ext_i`, or any `irq_req_i` bit whose wake-mask bit is set (bits 0 to 3 by default), releases it. `phi_o` then inverts on the next selected rising edge.
- R9: `irq_req_i` bits whose wake-mask bit is clear (bits 4 to 7 by default) do not release a wait.
- R10: When register 1 bit 0 is 1, `clkctl_o` is 1, except from the clock after stop entry until the clock after `irq_ext_i` ends the stop, when it is 0. When the bit is 0, `clkctl_o` is 0.
- R11: If `stop_req_i` and `wait_req_i` arrive together, the block stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the oscillators |
| rst_n | input | 1 | Synchronous active-low reset |
| main_osc_i | input | 1 | Main oscillator level |
| sub_osc_i | input | 1 | Sub-oscillator level |
| stop_req_i | input | 1 | Stop request pulse |
| wait_req_i | input | 1 | Wait request pulse |
| irq_ext_i | input | 1 | External interrupt |
| irq_req_i | input | NIRQ | Other interrupt requests |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | DW | Register write data |
| phi_o | output | 1 | Gated internal clock |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub-oscillator enable |
| osc_drive_strong_o | output | 1 | Strong oscillator drive select |
| clkctl_o | output | 1 | Clock-control status pin |

## Verification
A wrong power state shows at the ports within one clock. `phi_o` stops toggling or keeps toggling when it should not, and the oscillator enables or `clkctl_o` take the wrong level. A miscounted prescaler or cascade stage moves the first `phi_o` edge after a stop. The error is a whole multiple of 16 source edges, so the edge number itself points to which stage is at fault. A wrong source selection changes the `phi_o` toggle rate, which shows within one sub-oscillator period.

// File: rtl/lpclk_pkg.sv
// Shared types and register layout for the low-power clock controller.
// Assumes an 8-bit register write path; register indices are fixed here.
package lpclk_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2,
        PM_STAB = 2'd3
    } pm_state_e;

    localparam logic [1:0] REG_MODE = 2'd0;
    localparam logic [1:0] REG_CTL  = 2'd1;
    localparam logic [1:0] REG_T3   = 2'd2;
    localparam logic [1:0] REG_T4   = 2'd3;

    localparam int MODE_SLOW_BIT    = 7;
    localparam int MODE_MAINOFF_BIT = 6;
    localparam int MODE_DRV_BIT     = 5;
    localparam int CTL_USER_BIT     = 7;
    localparam int CTL_PIN_BIT      = 0;

endpackage

// File: rtl/lpclk_regs.sv
// Register file: mode bits, control bits and the two user start values.
// Assumes single-cycle writes; stores only the bits the block uses.
module lpclk_regs
    import lpclk_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [1:0]    sel_i,
    input  logic [DW-1:0] wdata_i,
    output logic          slow_sel_o,
    output logic          main_off_o,
    output logic          drv_strong_o,
    output logic          use_user_o,
    output logic          pin_en_o,
    output logic [TW-1:0] t3_user_o,
    output logic [TW-1:0] t4_user_o
);

    // Capture register writes; drive strength resets to strong.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_sel_o   <= 1'b0;
            main_off_o   <= 1'b0;
            drv_strong_o <= 1'b1;
            use_user_o   <= 1'b0;
            pin_en_o     <= 1'b0;
            t3_user_o    <= '0;
            t4_user_o    <= '0;
        end else if (we_i) begin
            unique case (sel_i)
                REG_MODE: begin
                    slow_sel_o   <= wdata_i[MODE_SLOW_BIT];
                    main_off_o   <= wdata_i[MODE_MAINOFF_BIT];
                    drv_strong_o <= wdata_i[MODE_DRV_BIT];
                end
                REG_CTL: begin
                    use_user_o <= wdata_i[CTL_USER_BIT];
                    pin_en_o   <= wdata_i[CTL_PIN_BIT];
                end
                REG_T3:  t3_user_o <= wdata_i[TW-1:0];
                REG_T4:  t4_user_o <= wdata_i[TW-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lpclk_srcsel.sv
// Source selector and gated clock generator.
// Detects rising edges of both sampled oscillators, switches the source
// only when both levels are low, and toggles phi on each selected edge
// unless a hold is requested, in which case phi is forced high.
module lpclk_srcsel (
    input  logic clk,
    input  logic rst_n,
    input  logic main_i,
    input  logic sub_i,
    input  logic want_slow_i,
    input  logic hold_i,
    output logic src_rise_o,
    output logic sel_slow_o,
    output logic phi_o
);

    logic main_q;
    logic sub_q;
    logic main_rise;
    logic sub_rise;

    // Remember last sampled oscillator levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= 1'b0;
            sub_q  <= 1'b0;
        end else begin
            main_q <= main_i;
            sub_q  <= sub_i;
        end
    end

    assign main_rise  = main_i & ~main_q;
    assign sub_rise   = sub_i & ~sub_q;
    assign src_rise_o = sel_slow_o ? sub_rise : main_rise;

    // Apply a pending source change only while both oscillators are low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_slow_o <= 1'b0;
        end else if ((want_slow_i != sel_slow_o) && !main_i && !sub_i) begin
            sel_slow_o <= want_slow_i;
        end
    end

    // Gated clock: forced high on hold, otherwise divide selected source by two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phi_o <= 1'b1;
        end else if (hold_i) begin
            phi_o <= 1'b1;
        end else if (src_rise_o) begin
            phi_o <= ~phi_o;
        end
    end

endmodule

// File: rtl/lpclk_stab.sv
// Oscillator stabilisation countdown.
// A prescaler divides selected-source edges by PRE_DIV; its ticks drive a
// first stage that reloads on underflow and decrements a second stage.
// done_o pulses on the tick where both stages are already zero.
// Assumes load_i and run_i are never high together.
module lpclk_stab #(
    parameter int TW      = 8,
    parameter int PRE_DIV = 16,
    parameter int T3_DEF  = 255,
    parameter int T4_DEF  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          run_i,
    input  logic          src_rise_i,
    input  logic          use_user_i,
    input  logic [TW-1:0] t3_user_i,
    input  logic [TW-1:0] t4_user_i,
    output logic          done_o
);

    localparam int          PW     = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [TW-1:0] T3_INIT = TW'(T3_DEF);
    localparam logic [TW-1:0] T4_INIT = TW'(T4_DEF);

    logic          tick;
    logic [TW-1:0] t3_q;
    logic [TW-1:0] t3_rl_q;
    logic [TW-1:0] t4_q;

    generate
        if (PRE_DIV > 1) begin : g_pre
            localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
            logic [PW-1:0] pre_q;

            // Count selected-source edges modulo PRE_DIV while stabilising.
            always_ff @(posedge clk) begin
                if (!rst_n || load_i) begin
                    pre_q <= '0;
                end else if (run_i && src_rise_i) begin
                    pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
                end
            end

            assign tick = run_i && src_rise_i && (pre_q == PRE_LAST);
        end else begin : g_nopre
            assign tick = run_i && src_rise_i;
        end
    endgenerate

    // Load start values on stop entry, then count the cascade down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t3_q    <= T3_INIT;
            t3_rl_q <= T3_INIT;
            t4_q    <= T4_INIT;
        end else if (load_i) begin
            t3_q    <= use_user_i ? t3_user_i : T3_INIT;
            t3_rl_q <= use_user_i ? t3_user_i : T3_INIT;
            t4_q    <= use_user_i ? t4_user_i : T4_INIT;
        end else if (tick) begin
            if (t3_q == '0) begin
                t3_q <= t3_rl_q;
                if (t4_q != '0) begin
                    t4_q <= t4_q - 1'b1;
                end
            end else begin
                t3_q <= t3_q - 1'b1;
            end
        end
    end

    assign done_o = tick && (t3_q == '0) && (t4_q == '0);

endmodule

// File: rtl/lpclk_fsm.sv
// Power-state sequencer: run, wait, stop and stabilise.
// Stop has priority over wait; requests are honoured only while running.
// Wait ends on the external interrupt or any request enabled in WAKE_MASK.
module lpclk_fsm
    import lpclk_pkg::*;
#(
    parameter int             NIRQ      = 8,
    parameter logic [NIRQ-1:0] WAKE_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_req_i,
    input  logic            wait_req_i,
    input  logic            irq_ext_i,
    input  logic [NIRQ-1:0] irq_req_i,
    input  logic            stab_done_i,
    output pm_state_e       st_q,
    output pm_state_e       st_nx
);

    logic wait_wake;

    assign wait_wake = irq_ext_i || (|(irq_req_i & WAKE_MASK));

    // Next-state selection for the power modes.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PM_RUN: begin
                if (stop_req_i) begin
                    st_nx = PM_STOP;
                end else if (wait_req_i) begin
                    st_nx = PM_WAIT;
                end
            end
            PM_WAIT: if (wait_wake)   st_nx = PM_RUN;
            PM_STOP: if (irq_ext_i)   st_nx = PM_STAB;
            PM_STAB: if (stab_done_i) st_nx = PM_RUN;
            default: st_nx = PM_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PM_RUN;
        end else begin
            st_q <= st_nx;
        end
    end

endmodule

// File: rtl/lpclk_ctrl.sv
// Low-power clock mode controller top.
// Ties the register file, state sequencer, source selector and
// stabilisation countdown together and derives the oscillator controls
// and the status pin. Oscillator inputs are levels sampled on clk.
module lpclk_ctrl
    import lpclk_pkg::*;
#(
    parameter int              NIRQ      = 8,
    parameter logic [NIRQ-1:0] WAKE_MASK = 8'h0F,
    parameter int              DW        = 8,
    parameter int              TW        = 8,
    parameter int              PRE_DIV   = 16,
    parameter int              T3_DEF    = 255,
    parameter int              T4_DEF    = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            main_osc_i,
    input  logic            sub_osc_i,
    input  logic            stop_req_i,
    input  logic            wait_req_i,
    input  logic            irq_ext_i,
    input  logic [NIRQ-1:0] irq_req_i,
    input  logic            reg_we_i,
    input  logic [1:0]      reg_sel_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic            phi_o,
    output logic            main_osc_en_o,
    output logic            sub_osc_en_o,
    output logic            osc_drive_strong_o,
    output logic            clkctl_o
);

    pm_state_e     st_q;
    pm_state_e     st_nx;
    logic          slow_sel;
    logic          main_off;
    logic          use_user;
    logic          pin_en;
    logic [TW-1:0] t3_user;
    logic [TW-1:0] t4_user;
    logic          src_rise;
    logic          sel_slow;
    logic          stab_done;
    logic          hold;
    logic          stop_load;
    logic          osc_off;

    lpclk_regs #(
        .DW (DW),
        .TW (TW)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (reg_we_i),
        .sel_i        (reg_sel_i),
        .wdata_i      (reg_wdata_i),
        .slow_sel_o   (slow_sel),
        .main_off_o   (main_off),
        .drv_strong_o (osc_drive_strong_o),
        .use_user_o   (use_user),
        .pin_en_o     (pin_en),
        .t3_user_o    (t3_user),
        .t4_user_o    (t4_user)
    );

    lpclk_fsm #(
        .NIRQ      (NIRQ),
        .WAKE_MASK (WAKE_MASK)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req_i  (stop_req_i),
        .wait_req_i  (wait_req_i),
        .irq_ext_i   (irq_ext_i),
        .irq_req_i   (irq_req_i),
        .stab_done_i (stab_done),
        .st_q        (st_q),
        .st_nx       (st_nx)
    );

    // Hold phi high in every non-run state and on the edge that leaves run.
    assign hold      = (st_q != PM_RUN) || (st_nx != PM_RUN);
    assign stop_load = (st_q == PM_RUN) && (st_nx == PM_STOP);
    assign osc_off   = (st_q == PM_STOP);

    lpclk_srcsel u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_i      (main_osc_i),
        .sub_i       (sub_osc_i),
        .want_slow_i (slow_sel),
        .hold_i      (hold),
        .src_rise_o  (src_rise),
        .sel_slow_o  (sel_slow),
        .phi_o       (phi_o)
    );

    lpclk_stab #(
        .TW      (TW),
        .PRE_DIV (PRE_DIV),
        .T3_DEF  (T3_DEF),
        .T4_DEF  (T4_DEF)
    ) u_stab (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (stop_load),
        .run_i      (st_q == PM_STAB),
        .src_rise_i (src_rise),
        .use_user_i (use_user),
        .t3_user_i  (t3_user),
        .t4_user_i  (t4_user),
        .done_o     (stab_done)
    );

    assign main_osc_en_o = !osc_off && !main_off;
    assign sub_osc_en_o  = !osc_off;
    assign clkctl_o      = pin_en && !osc_off;

endmodule

// File: rtl/lpclk_ctrl_chk.sv
// Property checker for the low-power clock controller, bound to the top.
module lpclk_ctrl_chk
    import lpclk_pkg::*;
#(
    parameter int              NIRQ      = 8,
    parameter logic [NIRQ-1:0] WAKE_MASK = 8'h0F
) (
    input logic            clk,
    input logic            rst_n,
    input pm_state_e       st_q,
    input logic            stop_req_i,
    input logic            wait_req_i,
    input logic            irq_ext_i,
    input logic [NIRQ-1:0] irq_req_i,
    input logic            main_osc_i,
    input logic            sub_osc_i,
    input logic            sel_slow,
    input logic            main_off,
    input logic            phi_o,
    input logic            main_osc_en_o,
    input logic            sub_osc_en_o,
    input logic            clkctl_o
);

    // R2
    src_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_slow != $past(sel_slow)) |-> (!$past(main_osc_i) && !$past(sub_osc_i)));

    // R3
    main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_off |-> !main_osc_en_o);

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PM_STOP) |-> (phi_o && !main_osc_en_o && !sub_osc_en_o));

    // R6
    stab_phi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PM_STAB) |-> (phi_o && sub_osc_en_o));

    // R8
    wait_phi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PM_WAIT) |-> (phi_o && sub_osc_en_o));

    // R9
    wait_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == PM_WAIT) && !irq_ext_i && ((irq_req_i & WAKE_MASK) == '0))
        |=> (st_q == PM_WAIT));

    // R10
    clkctl_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == PM_RUN) && stop_req_i) |=> !clkctl_o);

    // R11
    stop_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == PM_RUN) && stop_req_i && wait_req_i) |=> (st_q == PM_STOP));

endmodule

bind lpclk_ctrl lpclk_ctrl_chk #(
    .NIRQ      (NIRQ),
    .WAKE_MASK (WAKE_MASK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_q          (st_q),
    .stop_req_i    (stop_req_i),
    .wait_req_i    (wait_req_i),
    .irq_ext_i     (irq_ext_i),
    .irq_req_i     (irq_req_i),
    .main_osc_i    (main_osc_i),
    .sub_osc_i     (sub_osc_i),
    .sel_slow      (sel_slow),
    .main_off      (main_off),
    .phi_o         (phi_o),
    .main_osc_en_o (main_osc_en_o),
    .sub_osc_en_o  (sub_osc_en_o),
    .clkctl_o      (clkctl_o)
);

// File: tb/lpclk_ctrl_bench.sv
// Self-checking bench. Oscillators are derived from a free-running cycle
// counter: main toggles every clock, sub has a six-clock period.
module lpclk_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       wait_req = 1'b0;
    logic       irq_ext = 1'b0;
    logic [7:0] irq_req = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic       main_osc;
    logic       sub_osc;
    logic       phi;
    logic       main_en;
    logic       sub_en;
    logic       drv;
    logic       clkctl;
    int unsigned cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit fin = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    assign main_osc = cyc[0];
    assign sub_osc  = (cyc % 6) >= 3;

    lpclk_ctrl u_lpclk_ctrl (
        .clk                (clk),
        .rst_n              (rst_n),
        .main_osc_i         (main_osc),
        .sub_osc_i          (sub_osc),
        .stop_req_i         (stop_req),
        .wait_req_i         (wait_req),
        .irq_ext_i          (irq_ext),
        .irq_req_i          (irq_req),
        .reg_we_i           (reg_we),
        .reg_sel_i          (reg_sel),
        .reg_wdata_i        (reg_wdata),
        .phi_o              (phi),
        .main_osc_en_o      (main_en),
        .sub_osc_en_o       (sub_en),
        .osc_drive_strong_o (drv),
        .clkctl_o           (clkctl)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic count_toggles(int n, output int t);
        logic p;
        t = 0;
        @(negedge clk);
        p = phi;
        repeat (n) begin
            @(negedge clk);
            if (phi !== p) t++;
            p = phi;
        end
    endtask

    task automatic do_stop(bit with_wait);
        @(negedge clk);
        stop_req = 1'b1; wait_req = with_wait;
        @(negedge clk);
        stop_req = 1'b0; wait_req = 1'b0;
    endtask

    // Wake from stop and check the edge on which phi first falls.
    task automatic stab_measure(int n_exp, string tag);
        int unsigned c0;
        int unsigned first;
        int k;
        @(negedge clk);
        irq_ext = 1'b1;
        c0 = cyc;
        @(negedge clk);
        irq_ext = 1'b0;
        chk(tag, sub_en, 1);
        k = 0;
        while (phi === 1'b1 && k < 80000) begin
            @(negedge clk);
            k++;
        end
        first = (c0 % 2 == 0) ? c0 + 1 : c0 + 2;
        chk(tag, int'(cyc), int'(first + 2 * n_exp + 1));
    endtask

    initial begin
        int t;
        int lows;
        repeat (3) @(negedge clk);
        // R1 R4 R10 reset state
        chk("R1", phi, 1);
        chk("R1", main_en, 1);
        chk("R1", sub_en, 1);
        chk("R4", drv, 1);
        chk("R10", clkctl, 0);
        rst_n = 1'b1;

        // R1 half main rate
        count_toggles(40, t);
        chk("R1", t, 20);

        // R2 slow source, then back to fast; R4 drive follows bit 5
        wr(2'd0, 8'hA0);
        repeat (12) @(negedge clk);
        count_toggles(60, t);
        chk("R2", t, 10);
        wr(2'd0, 8'h00);
        chk("R4", drv, 0);
        repeat (12) @(negedge clk);
        count_toggles(40, t);
        chk("R2", t, 20);

        // R3 main oscillator off
        wr(2'd0, 8'h40);
        chk("R3", main_en, 0);
        chk("R3", sub_en, 1);
        wr(2'd0, 8'h20);
        chk("R3", main_en, 1);
        chk("R4", drv, 1);

        // R10 pin enabled
        wr(2'd1, 8'h01);
        chk("R10", clkctl, 1);

        // R5 stop entry, other requests ignored
        do_stop(1'b0);
        chk("R5", phi, 1);
        chk("R5", main_en, 0);
        chk("R5", sub_en, 0);
        chk("R10", clkctl, 0);
        irq_req = 8'hFF;
        wait_req = 1'b1;
        lows = 0;
        repeat (20) begin
            @(negedge clk);
            if (phi !== 1'b1 || sub_en !== 1'b0 || clkctl !== 1'b0) lows++;
        end
        irq_req = '0;
        wait_req = 1'b0;
        chk("R5", lows, 0);

        // R6 R7 default start values
        stab_measure(16 * 256 * 8, "R7");
        chk("R10", clkctl, 1);
        chk("R6", main_en, 1);

        // R6 R7 sweep of user start values
        wr(2'd1, 8'h81);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 3; b++) begin
                wr(2'd2, 8'(a * 2));
                wr(2'd3, 8'(b));
                do_stop(1'b0);
                stab_measure(16 * (a * 2 + 1) * (b + 1), "R6");
            end
        end

        // R8 R9 wait: blocked sources hold, allowed sources release
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            wait_req = 1'b1;
            @(negedge clk);
            wait_req = 1'b0;
            chk("R8", main_en, 1);
            irq_req = 8'h80 >> (b % 4);
            lows = 0;
            repeat (8) begin
                @(negedge clk);
                if (phi !== 1'b1) lows++;
            end
            chk("R9", lows, 0);
            if (b < 4) irq_req = 8'h01 << b;
            else begin
                irq_req = '0;
                irq_ext = 1'b1;
            end
            @(negedge clk);
            irq_req = '0;
            irq_ext = 1'b0;
            count_toggles(8, t);
            chk("R8", t, 4);
        end

        // R11 stop wins over simultaneous wait
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        do_stop(1'b1);
        chk("R11", main_en, 0);
        chk("R11", clkctl, 0);
        stab_measure(16, "R11");

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule